// File: doc/BRIEF.md
# Two-Level Paged Address Translator

This block turns a 32-bit logical address into a physical address for a 1 KB page size. It first searches a small fully associative translation cache, with every entry compared in parallel against the 22-bit virtual page number. A hit yields the frame number without touching memory. A miss starts a two-step walk through a page table held in main memory. The 12 upper bits of the address index an outer table whose start address comes from a base input. The outer entry that is read locates an inner table, and the next 10 bits select the final entry within it. The low 10 bits pass through to the physical address unchanged.

Each table entry is a 32-bit word. Bit 0 marks the entry valid and bits [31:10] carry a frame number. An outer index that is not below the table-length input is rejected before any memory traffic, as a length fault. An invalid entry at either level ends the walk with a page fault. A walk that succeeds writes its result into the cache, replacing entries in round-robin order. A flush input empties the cache.

The requester sees a valid/ready request port and a one-cycle response pulse. Page-table words are fetched over a simple read port that never has more than one read outstanding.

Top module: `xlat_top`

## Requirements
- R1: A successful translation returns `rsp_paddr` = {frame number, `req_vaddr[9:0]`}, so the page offset is unchanged. The address splits as outer index `[31:20]`, inner index `[19:10]` and offset `[9:0]`.
- R2: When the page number hits a valid cache entry, `rsp_valid` rises on the second clock edge after the request is accepted, with `rsp_fault` = 2'b00 and no memory read. At most one entry ever matches.
- R3: On a miss with a legal outer index, exactly two reads are issued. The first goes to `pt_base + 4*outer`. The second goes to {outer entry bits [31:10], 10'b0} + 4*inner. The physical frame is taken from bits [31:10] of the second word.
- R4: When the outer index is greater than or equal to `pt_len` and the cache misses, the response carries `rsp_fault` = 2'b01 (length fault). It arrives on the second edge after acceptance, and no memory read is issued.
- R5: An outer entry with bit 0 clear ends the walk after one read with `rsp_fault` = 2'b10 (page fault), and nothing is written into the cache.
- R6: An inner entry with bit 0 clear ends the walk after two reads with `rsp_fault` = 2'b10, and nothing is written into the cache.
- R7: The cache holds 8 entries. Each successful walk fills the slot named by a round-robin pointer, which starts at slot 0 after reset and advances only on a fill. The ninth distinct page therefore evicts the first one.
- R8: A one-cycle `flush` pulse invalidates every cache entry by the next clock edge, so the next access to a previously cached page walks memory again.
- R9: `mem_req_valid` is a one-cycle pulse. No new read starts before `mem_rsp_valid` has returned the previous one.
- R10: `rsp_valid` is high for exactly one cycle. `req_ready` is high only while the block is idle. A faulting response drives `rsp_paddr` to zero.
- R11: After reset, `req_ready` = 1, `rsp_valid` = 0, `mem_req_valid` = 0, and every cache entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all translation cache entries |
| pt_base | input | 32 | Byte address of the outer page table |
| pt_len | input | 13 | Number of legal outer-table entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 00 none, 01 length fault, 10 page fault |
| mem_req_valid | output | 1 | Page-table read strobe |
| mem_req_addr | output | 32 | Byte address of the page-table word |
| mem_rsp_valid | input | 1 | Page-table read data present |
| mem_rsp_data | input | 32 | Page-table word returned |

## Verification
The bench targets eviction order. It fills all eight slots and then revisits pages that a wrong pointer would have kept or dropped, so a design that replaced the wrong slot would report an extra hit or an extra walk. It places invalid entries at the outer level and at the inner level separately, which catches a design that checks only one level, caches a faulting walk, or issues a second read after an outer fault. It probes both edges of the length bound, one below the limit and the largest possible outer index. A design with an off-by-one compare there would either walk an illegal index or reject a legal one. The flush test re-reads a page that was just cached, so a design whose flush left any entry valid would answer from the stale entry.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_LEN  = 2'b01,
      FLT_PAGE = 2'b10
   } fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_OREQ,
      ST_OWAIT,
      ST_IREQ,
      ST_IWAIT,
      ST_RESP
   } walk_st_e;
endpackage

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb #(
   parameter int VPN_W   = 22,
   parameter int FRAME_W = 22,
   parameter int ENTRIES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [VPN_W-1:0]   look_vpn,
   output logic               hit,
   output logic [FRAME_W-1:0] hit_frame,
   output logic [ENTRIES-1:0] hit_vec,
   output logic [ENTRIES-1:0] valid_vec,
   input  logic               fill_en,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [FRAME_W-1:0] fill_frame
);
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

   logic [PTR_W-1:0]   victim_q;
   logic [FRAME_W-1:0] frame_arr [ENTRIES];

   genvar g;
   generate
      for (g = 0; g < ENTRIES; g++) begin : g_slot
         logic               v_q;
         logic [VPN_W-1:0]   tag_q;
         logic [FRAME_W-1:0] frm_q;
         wire                pick = fill_en && (victim_q == PTR_W'(g));

         always_ff @(posedge clk) begin
            if (!rst_n)     v_q <= 1'b0;
            else if (flush) v_q <= 1'b0;
            else if (pick)  v_q <= 1'b1;
         end

         always_ff @(posedge clk) begin
            if (pick) begin
               tag_q <= fill_vpn;
               frm_q <= fill_frame;
            end
         end

         assign valid_vec[g] = v_q;
         assign hit_vec[g]   = v_q && (tag_q == look_vpn);
         assign frame_arr[g] = frm_q;
      end
   endgenerate

   always_comb begin
      hit_frame = '0;
      for (int k = 0; k < ENTRIES; k++) begin
         if (hit_vec[k]) hit_frame = hit_frame | frame_arr[k];
      end
   end

   assign hit = |hit_vec;

   always_ff @(posedge clk) begin
      if (!rst_n)       victim_q <= '0;
      else if (fill_en) victim_q <= (victim_q == PTR_LAST) ? '0 : victim_q + 1'b1;
   end
endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int OFF_W  = 10,
   parameter int IDX1_W = 12,
   parameter int IDX2_W = 10,
   parameter int PTE_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [VA_W-1:0]           req_vaddr,
   input  logic [PTE_W-1:0]          pt_base,
   input  logic [IDX1_W:0]           pt_len,
   output logic [VA_W-OFF_W-1:0]     look_vpn,
   input  logic                      tlb_hit,
   input  logic [PTE_W-OFF_W-1:0]    tlb_frame,
   output logic                      fill_en,
   output logic [VA_W-OFF_W-1:0]     fill_vpn,
   output logic [PTE_W-OFF_W-1:0]    fill_frame,
   output logic                      mem_req_valid,
   output logic [PTE_W-1:0]          mem_req_addr,
   input  logic                      mem_rsp_valid,
   input  logic [PTE_W-1:0]          mem_rsp_data,
   output logic                      rsp_valid,
   output logic [PTE_W-1:0]          rsp_paddr,
   output logic [1:0]                rsp_fault
);
   localparam int FRAME_W = PTE_W - OFF_W;
   localparam int ESH     = $clog2(PTE_W / 8);

   walk_st_e             state_q;
   logic [VA_W-1:0]      vaddr_q;
   logic [FRAME_W-1:0]   link_q;
   logic [PTE_W-1:0]     paddr_q;
   fault_e               fault_q;

   logic [IDX1_W-1:0]    outer_idx;
   logic [IDX2_W-1:0]    inner_idx;
   logic [OFF_W-1:0]     offset;
   logic [PTE_W-1:0]     outer_addr;
   logic [PTE_W-1:0]     inner_addr;
   logic                 len_bad;
   logic                 pte_ok;
   logic [FRAME_W-1:0]   pte_frame;
   logic                 pte_spare_unused;

   assign outer_idx  = vaddr_q[VA_W-1 -: IDX1_W];
   assign inner_idx  = vaddr_q[OFF_W +: IDX2_W];
   assign offset     = vaddr_q[OFF_W-1:0];
   assign outer_addr = pt_base + (PTE_W'(outer_idx) << ESH);
   assign inner_addr = {link_q, {OFF_W{1'b0}}} + (PTE_W'(inner_idx) << ESH);
   assign len_bad    = ({1'b0, outer_idx} >= pt_len);
   assign pte_ok     = mem_rsp_data[0];
   assign pte_frame  = mem_rsp_data[PTE_W-1:OFF_W];
   assign pte_spare_unused = ^mem_rsp_data[OFF_W-1:1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vaddr_q <= '0;
         link_q  <= '0;
         paddr_q <= '0;
         fault_q <= FLT_NONE;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               vaddr_q <= req_vaddr;
               state_q <= ST_LOOK;
            end
            ST_LOOK: begin
               if (tlb_hit) begin
                  paddr_q <= {tlb_frame, offset};
                  fault_q <= FLT_NONE;
                  state_q <= ST_RESP;
               end else if (len_bad) begin
                  paddr_q <= '0;
                  fault_q <= FLT_LEN;
                  state_q <= ST_RESP;
               end else begin
                  state_q <= ST_OREQ;
               end
            end
            ST_OREQ: state_q <= ST_OWAIT;
            ST_OWAIT: if (mem_rsp_valid) begin
               if (!pte_ok) begin
                  paddr_q <= '0;
                  fault_q <= FLT_PAGE;
                  state_q <= ST_RESP;
               end else begin
                  link_q  <= pte_frame;
                  state_q <= ST_IREQ;
               end
            end
            ST_IREQ: state_q <= ST_IWAIT;
            ST_IWAIT: if (mem_rsp_valid) begin
               if (!pte_ok) begin
                  paddr_q <= '0;
                  fault_q <= FLT_PAGE;
               end else begin
                  paddr_q <= {pte_frame, offset};
                  fault_q <= FLT_NONE;
               end
               state_q <= ST_RESP;
            end
            ST_RESP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign rsp_valid     = (state_q == ST_RESP);
   assign rsp_paddr     = paddr_q;
   assign rsp_fault     = fault_q;
   assign look_vpn      = vaddr_q[VA_W-1:OFF_W];
   assign mem_req_valid = (state_q == ST_OREQ) || (state_q == ST_IREQ);
   assign mem_req_addr  = (state_q == ST_OREQ) ? outer_addr : inner_addr;
   assign fill_en       = (state_q == ST_IWAIT) && mem_rsp_valid && pte_ok;
   assign fill_vpn      = vaddr_q[VA_W-1:OFF_W];
   assign fill_frame    = pte_frame;
endmodule

// File: rtl/xlat_top.sv
`timescale 1ns/1ps
module xlat_top #(
   parameter int VA_W        = 32,
   parameter int OFF_W       = 10,
   parameter int IDX1_W      = 12,
   parameter int IDX2_W      = 10,
   parameter int PTE_W       = 32,
   parameter int TLB_ENTRIES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [PTE_W-1:0]  pt_base,
   input  logic [IDX1_W:0]   pt_len,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              rsp_valid,
   output logic [PTE_W-1:0]  rsp_paddr,
   output logic [1:0]        rsp_fault,
   output logic              mem_req_valid,
   output logic [PTE_W-1:0]  mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data
);
   localparam int VPN_W   = IDX1_W + IDX2_W;
   localparam int FRAME_W = PTE_W - OFF_W;

   generate
      if (VA_W != VPN_W + OFF_W) begin : g_bad_split
         $error("address split does not add up to VA_W");
      end
      if (PTE_W <= OFF_W || (PTE_W % 8) != 0) begin : g_bad_pte
         $error("PTE_W must be a byte multiple wider than OFF_W");
      end
      if (TLB_ENTRIES < 2) begin : g_bad_depth
         $error("TLB_ENTRIES must be at least 2");
      end
   endgenerate

   logic [VPN_W-1:0]       look_vpn;
   logic                   tlb_hit;
   logic [FRAME_W-1:0]     tlb_frame;
   logic [TLB_ENTRIES-1:0] hit_vec;
   logic [TLB_ENTRIES-1:0] tlb_valid;
   logic                   fill_en;
   logic [VPN_W-1:0]       fill_vpn;
   logic [FRAME_W-1:0]     fill_frame;

   xlat_tlb #(
      .VPN_W   (VPN_W),
      .FRAME_W (FRAME_W),
      .ENTRIES (TLB_ENTRIES)
   ) u_tlb (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .look_vpn   (look_vpn),
      .hit        (tlb_hit),
      .hit_frame  (tlb_frame),
      .hit_vec    (hit_vec),
      .valid_vec  (tlb_valid),
      .fill_en    (fill_en),
      .fill_vpn   (fill_vpn),
      .fill_frame (fill_frame)
   );

   xlat_walker #(
      .VA_W   (VA_W),
      .OFF_W  (OFF_W),
      .IDX1_W (IDX1_W),
      .IDX2_W (IDX2_W),
      .PTE_W  (PTE_W)
   ) u_walk (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .pt_base       (pt_base),
      .pt_len        (pt_len),
      .look_vpn      (look_vpn),
      .tlb_hit       (tlb_hit),
      .tlb_frame     (tlb_frame),
      .fill_en       (fill_en),
      .fill_vpn      (fill_vpn),
      .fill_frame    (fill_frame),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .rsp_valid     (rsp_valid),
      .rsp_paddr     (rsp_paddr),
      .rsp_fault     (rsp_fault)
   );
endmodule

// File: rtl/xlat_chk.sv
`timescale 1ns/1ps
module xlat_chk #(
   parameter int N    = 8,
   parameter int PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            flush,
   input logic            req_ready,
   input logic            rsp_valid,
   input logic [1:0]      rsp_fault,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            mem_req_valid,
   input logic            mem_rsp_valid,
   input logic [N-1:0]    tlb_valid,
   input logic [N-1:0]    hit_vec
);
   // R10
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R10
   busy_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R10
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

   // R9
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   // R9
   read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !mem_rsp_valid);

   // R8
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (tlb_valid == '0));

   // R2
   onehot_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R11
   reset_empty_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (tlb_valid == '0));
endmodule

bind xlat_top xlat_chk #(.N(TLB_ENTRIES), .PA_W(PTE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .flush         (flush),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_fault     (rsp_fault),
   .rsp_paddr     (rsp_paddr),
   .mem_req_valid (mem_req_valid),
   .mem_rsp_valid (mem_rsp_valid),
   .tlb_valid     (tlb_valid),
   .hit_vec       (hit_vec)
);

// File: tb/xlat_top_bench.sv
`timescale 1ns/1ps
module xlat_top_bench;
   localparam logic [31:0] PTBR  = 32'h0010_0000;
   localparam logic [31:0] INNER = 32'h0040_0000;
   localparam int NV = 17;
   // {outer 12, inner 10, offset 10, fault 2, reads 2}
   localparam logic [35:0] VEC [NV] = '{
      {12'd1,    10'd2,    10'h003, 2'b00, 2'd2},
      {12'd1,    10'd2,    10'h155, 2'b00, 2'd0},
      {12'd5,    10'd9,    10'h001, 2'b10, 2'd1},
      {12'd2,    10'd7,    10'h004, 2'b10, 2'd2},
      {12'd20,   10'd0,    10'h000, 2'b01, 2'd0},
      {12'd4095, 10'd1023, 10'h3ff, 2'b01, 2'd0},
      {12'd19,   10'd1023, 10'h3ff, 2'b00, 2'd2},
      {12'd0,    10'd0,    10'h000, 2'b00, 2'd2},
      {12'd3,    10'd10,   10'h008, 2'b00, 2'd2},
      {12'd3,    10'd11,   10'h008, 2'b00, 2'd2},
      {12'd3,    10'd12,   10'h008, 2'b00, 2'd2},
      {12'd3,    10'd13,   10'h008, 2'b00, 2'd2},
      {12'd3,    10'd14,   10'h008, 2'b00, 2'd2},
      {12'd3,    10'd15,   10'h008, 2'b00, 2'd2},
      {12'd1,    10'd2,    10'h007, 2'b00, 2'd2},
      {12'd0,    10'd0,    10'h020, 2'b00, 2'd0},
      {12'd19,   10'd1023, 10'h000, 2'b00, 2'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [31:0] pt_base = PTBR;
   logic [12:0] pt_len = 13'd20;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   xlat_top u_xlat_top (
      .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base), .pt_len(pt_len),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [31:0] pte_at(input logic [31:0] a);
      logic [31:0] o, i;
      logic [21:0] fr;
      if (a < INNER) begin
         o = (a - PTBR) >> 2;
         pte_at = ((32'h1000 + o * 4) << 10) | {31'b0, (o != 32'd5)};
      end else begin
         o = (a - INNER) >> 12;
         i = (a >> 2) & 32'h3ff;
         fr = {o[7:0], i[9:0], 4'hA};
         pte_at = {fr, 9'b0, (i != 32'd7)};
      end
   endfunction

   function automatic logic [31:0] exp_pa(input logic [31:0] va);
      exp_pa = {va[27:20], va[19:10], 4'hA, va[9:0]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) mem_rsp_valid <= 1'b0;
      else        mem_rsp_valid <= mem_req_valid;
      mem_rsp_data <= pte_at(mem_req_addr);
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic xlate(input logic [31:0] va, output logic [31:0] pa,
                        output logic [1:0] flt, output int reads, output int lat,
                        output bit addr_ok, output bit tail_ok);
      logic [31:0] o32, i32;
      o32 = {20'b0, va[31:20]};
      i32 = {22'b0, va[19:10]};
      addr_ok = 1'b1;
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      reads = 0;
      while (!rsp_valid && lat < 100) begin
         if (mem_req_valid) begin
            if (reads == 0 && mem_req_addr != PTBR + o32 * 4) addr_ok = 1'b0;
            if (reads == 1 && mem_req_addr != INNER + o32 * 32'h1000 + i32 * 4) addr_ok = 1'b0;
            reads++;
         end
         @(negedge clk);
         lat++;
      end
      pa = rsp_paddr;
      flt = rsp_fault;
      @(negedge clk);
      tail_ok = !rsp_valid && req_ready;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] pa, va;
      logic [1:0]  flt;
      int          rd, lat;
      bit          aok, tok;
      string       tag;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R11 reset",
          {61'b0, req_ready, rsp_valid, mem_req_valid}, 64'h4);

      for (int n = 0; n < NV; n++) begin
         va = VEC[n][35:4];
         xlate(va, pa, flt, rd, lat, aok, tok);
         if (VEC[n][3:2] == 2'b01)      tag = "R4";
         else if (VEC[n][3:2] == 2'b10) tag = (VEC[n][1:0] == 2'd1) ? "R5" : "R6";
         else if (VEC[n][1:0] == 2'd0)  tag = "R2";
         else                           tag = "R3";
         if (n >= 13) tag = {tag, " R7"};
         chk(flt == VEC[n][3:2], {tag, " fault"}, flt, VEC[n][3:2]);
         chk(rd == int'(VEC[n][1:0]), {tag, " reads"}, rd, VEC[n][1:0]);
         chk(aok, "R3 walk addresses", aok, 1);
         chk(tok, "R10 response pulse", tok, 1);
         if (VEC[n][3:2] == 2'b00)
            chk(pa == exp_pa(va), "R1 paddr", pa, exp_pa(va));
         else
            chk(pa == 32'h0, "R10 fault paddr", pa, 0);
         if (VEC[n][1:0] == 2'd0)
            chk(lat == 2, {tag, " latency"}, lat, 2);
      end

      // R8: cached page walks again after a flush
      va = {12'd3, 10'd10, 10'h011};
      xlate(va, pa, flt, rd, lat, aok, tok);
      chk(rd == 0, "R8 pre-flush hit", rd, 0);
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      xlate(va, pa, flt, rd, lat, aok, tok);
      chk(rd == 2, "R8 post-flush walk", rd, 2);
      chk(pa == exp_pa(va), "R8 post-flush paddr", pa, exp_pa(va));

      // R4: lower the bound so a previously legal index faults
      pt_len = 13'd3;
      xlate({12'd3, 10'd20, 10'h0}, pa, flt, rd, lat, aok, tok);
      chk(flt == 2'b01 && rd == 0, "R4 bound equal", {flt, 8'(rd)}, 10'h100);
      // R4: index one below the bound still walks
      xlate({12'd2, 10'd20, 10'h5}, pa, flt, rd, lat, aok, tok);
      chk(flt == 2'b00 && rd == 2, "R4 below bound", {flt, 8'(rd)}, 10'h002);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule